// File: doc/BRIEF.md
# Block-Framed CRC16 Checksum Unit

This unit computes a 16-bit cyclic redundancy checksum one bit at a time over the data bits of a single card data block, as used on an SD/MMC-style data line. The surrounding data path clears it with a pulse at the start of each block. It then presents each data bit together with a valid strobe. The unit updates its remainder only on strobed cycles. The generator polynomial is x^16 + x^12 + x^5 + 1, and the remainder starts from zero.

When the data bits are finished, the data path raises `crc_phase`. In the transmit direction the unit then serves the frozen remainder as a bit stream, most significant bit first, advancing one bit per strobe. In the receive direction it compares each strobed incoming bit against the matching remainder bit. After the sixteenth bit it gives a one-cycle completion pulse, plus a failure pulse if any bit differed. In stream transfer mode the unit is bypassed: its state is frozen and it reports no checksum activity.

Top module: `sd_crc16`

## Requirements
- R1: After reset, `crc_rem` is 0x0000, `crc_done` and `crc_fail` are 0, and `crc_tx_bit` is 0 while `crc_phase` is 0.
- R2: A `blk_start` pulse in block mode (`stream_mode`=0) sets `crc_rem` to 0x0000 on the next clock edge, even if `bit_vld` is high in the same cycle.
- R3: In block mode with `crc_phase`=0, each cycle with `bit_vld`=1 folds `bit_in` into the remainder as the next-lower coefficient of M(x), so that `crc_rem` equals M(x)·x^16 mod (x^16+x^12+x^5+1). A single 1 bit gives 0x1021, and 4096 one-bits give 0x7FA1.
- R4: A cycle with `bit_vld`=0 and `blk_start`=0 leaves `crc_rem`, `crc_done` and `crc_fail` unaffected, whatever `bit_in` is.
- R5: While `stream_mode`=1, `crc_rem` holds, `blk_start` and strobes are ignored, `crc_done` and `crc_fail` stay 0, and `crc_tx_bit` is 0.
- R6: With `crc_phase`=1, `tx_dir`=1 (transmit), `crc_tx_bit` shows remainder bit 15-k before the k-th strobe (k = 0..15), which is MSB first, and `crc_rem` does not change during the checksum phase.
- R7: With `crc_phase`=1, `tx_dir`=0 (receive), `crc_done` is 1 for the one cycle after the sixteenth strobe. `crc_fail` is 1 in that same cycle exactly when any received bit differed from the remainder bit expected at its position. In transmit, `crc_done` pulses likewise and `crc_fail` stays 0.
- R8: Strobes after the sixteenth checksum bit, and before the next `blk_start`, are ignored: no further `crc_done`, and `crc_tx_bit` is 0.
- R9: `crc_done` and `crc_fail` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Clears remainder and checksum counter at block start |
| stream_mode | input | 1 | 1 = stream transfer, unit bypassed |
| crc_phase | input | 1 | 0 = data bits, 1 = checksum bits |
| tx_dir | input | 1 | 1 = transmit (serve checksum), 0 = receive (compare) |
| bit_vld | input | 1 | Strobe: `bit_in` is consumed this cycle |
| bit_in | input | 1 | Serial data or received checksum bit |
| crc_rem | output | 16 | Running remainder |
| crc_tx_bit | output | 1 | Current checksum bit to transmit |
| crc_done | output | 1 | One-cycle pulse after sixteenth checksum bit |
| crc_fail | output | 1 | One-cycle pulse on receive checksum mismatch |

## Verification
The assertions watch every cycle for the following. The remainder holds when there is no strobe, in stream mode, and during the checksum phase. The remainder is zero after a block-mode clear. Completion and failure are single-cycle pulses, and failure never occurs without completion. `crc_tx_bit` is silent outside the checksum phase. Only the bench's scenarios can show that the remainder equals the polynomial division for real bit patterns. They also show that the checksum leaves MSB first, that a single flipped received bit is caught while a correct checksum passes, and that strobes beyond the sixteenth are ignored.

// File: rtl/sd_crc16_pkg.sv
package sd_crc16_pkg;
    localparam int unsigned CRC_WIDTH_DEF = 16;
    localparam logic [15:0] CRC_POLY_DEF  = 16'h1021;

    typedef enum logic {
        CRC_DIR_RX = 1'b0,
        CRC_DIR_TX = 1'b1
    } crc_dir_e;
endpackage

// File: rtl/sd_crc16_step.sv
// One serial division step: feedback = incoming bit xor remainder MSB.
module sd_crc16_step #(
    parameter int unsigned       W    = 16,
    parameter logic [W-1:0]      POLY = 16'h1021
) (
    input  logic [W-1:0] rem_cur,
    input  logic         din,
    output logic [W-1:0] rem_nxt
);
    logic fb;
    assign fb = din ^ rem_cur[W-1];

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign rem_nxt[i] = POLY[i] & fb;
        end else begin : g_upper
            assign rem_nxt[i] = rem_cur[i-1] ^ (POLY[i] & fb);
        end
    end
endmodule

// File: rtl/sd_crc16_bitsel.sv
// Picks remainder bit W-1-idx (MSB first); 0 once idx reaches W.
module sd_crc16_bitsel #(
    parameter int unsigned W     = 16,
    parameter int unsigned IDX_W = 5
) (
    input  logic [W-1:0]     vec,
    input  logic [IDX_W-1:0] idx,
    output logic             sel
);
    always_comb begin
        sel = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx == IDX_W'(i)) sel = vec[W-1-i];
        end
    end
endmodule

// File: rtl/sd_crc16.sv
module sd_crc16
    import sd_crc16_pkg::*;
#(
    parameter int unsigned          CRC_W = CRC_WIDTH_DEF,
    parameter logic [CRC_W-1:0]     POLY  = CRC_POLY_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_start,
    input  logic             stream_mode,
    input  logic             crc_phase,
    input  logic             tx_dir,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_rem,
    output logic             crc_tx_bit,
    output logic             crc_done,
    output logic             crc_fail
);
    localparam int unsigned CNT_W = $clog2(CRC_W + 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(CRC_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CRC_W - 1);

    typedef struct packed {
        logic [CRC_W-1:0] rem;
        logic [CNT_W-1:0] cnt;
        logic             miss;
        logic             done;
        logic             fail;
    } st_t;

    st_t st_d, st_q;

    logic [CRC_W-1:0] rem_step;
    logic             exp_bit;
    logic             bit_bad;
    crc_dir_e         dir;

    assign dir = crc_dir_e'(tx_dir);

    sd_crc16_step #(.W(CRC_W), .POLY(POLY)) u_step (
        .rem_cur (st_q.rem),
        .din     (bit_in),
        .rem_nxt (rem_step)
    );

    sd_crc16_bitsel #(.W(CRC_W), .IDX_W(CNT_W)) u_sel (
        .vec (st_q.rem),
        .idx (st_q.cnt),
        .sel (exp_bit)
    );

    assign bit_bad = bit_in ^ exp_bit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.fail = 1'b0;
        if (!stream_mode) begin
            if (blk_start) begin
                st_d.rem  = '0;
                st_d.cnt  = '0;
                st_d.miss = 1'b0;
            end else if (bit_vld) begin
                if (!crc_phase) begin
                    st_d.rem = rem_step;
                end else if (st_q.cnt != CNT_END) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (dir == CRC_DIR_RX) begin
                        st_d.miss = st_q.miss | bit_bad;
                    end
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.done = 1'b1;
                        st_d.fail = (dir == CRC_DIR_RX) && (st_q.miss | bit_bad);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_rem    = st_q.rem;
    assign crc_done   = st_q.done;
    assign crc_fail   = st_q.fail;
    assign crc_tx_bit = !stream_mode && crc_phase && (dir == CRC_DIR_TX) && exp_bit;
endmodule

// File: rtl/sd_crc16_chk.sv
module sd_crc16_chk #(
    parameter int unsigned CRC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             blk_start,
    input logic             stream_mode,
    input logic             crc_phase,
    input logic             bit_vld,
    input logic [CRC_W-1:0] crc_rem,
    input logic             crc_tx_bit,
    input logic             crc_done,
    input logic             crc_fail
);
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start && !stream_mode |=> crc_rem == '0);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld && !blk_start |=> $stable(crc_rem) && !crc_done);

    // R5
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_mode |=> $stable(crc_rem) && !crc_done && !crc_fail);

    // R5
    stream_tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_mode |-> !crc_tx_bit);

    // R6
    crc_phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_phase && !blk_start |=> $stable(crc_rem));

    // R1
    tx_quiet_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_phase |-> !crc_tx_bit);

    // R7
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_fail |-> crc_done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |=> !crc_done);

    // R9
    fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_fail |=> !crc_fail);
endmodule

bind sd_crc16 sd_crc16_chk #(.CRC_W(CRC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start   (blk_start),
    .stream_mode (stream_mode),
    .crc_phase   (crc_phase),
    .bit_vld     (bit_vld),
    .crc_rem     (crc_rem),
    .crc_tx_bit  (crc_tx_bit),
    .crc_done    (crc_done),
    .crc_fail    (crc_fail)
);

// File: tb/sd_crc16_tb.sv
`timescale 1ns/1ps
module sd_crc16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_start = 1'b0;
    logic        stream_mode = 1'b0;
    logic        crc_phase = 1'b0;
    logic        tx_dir = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] crc_rem;
    logic        crc_tx_bit;
    logic        crc_done;
    logic        crc_fail;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  ended   = 1'b0;
    logic [15:0] model;
    logic        tx_seen;

    always #2.5 clk = ~clk;

    sd_crc16 u_dut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
        .stream_mode(stream_mode), .crc_phase(crc_phase), .tx_dir(tx_dir),
        .bit_vld(bit_vld), .bit_in(bit_in), .crc_rem(crc_rem),
        .crc_tx_bit(crc_tx_bit), .crc_done(crc_done), .crc_fail(crc_fail)
    );

    function automatic logic [15:0] model_bit(logic [15:0] r, logic b);
        logic top;
        top = r[15];
        r   = r << 1;
        if (top != b) r = r ^ 16'h1021;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle; tx_seen captures crc_tx_bit before the edge.
    task automatic cyc(logic st, logic v, logic b);
        blk_start = st; bit_vld = v; bit_in = b;
        #1;
        tx_seen = crc_tx_bit;
        @(posedge clk); #1;
        blk_start = 1'b0; bit_vld = 1'b0;
    endtask

    task automatic start_block();
        crc_phase = 1'b0;
        cyc(1'b1, 1'b0, 1'b0);
        model = 16'h0000;
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            cyc(1'b0, 1'b1, v[i]);
            model = model_bit(model, v[i]);
        end
    endtask

    task automatic t_reset();
        check("R1 rem", {16'h0, crc_rem}, 32'h0);
        check("R1 done", {31'h0, crc_done}, 32'h0);
        check("R1 fail", {31'h0, crc_fail}, 32'h0);
        check("R1 tx_bit", {31'h0, crc_tx_bit}, 32'h0);
    endtask

    task automatic t_single_and_idle();
        start_block();
        cyc(1'b0, 1'b1, 1'b1);
        check("R3 single one", {16'h0, crc_rem}, 32'h1021);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, i[0]);
        check("R4 idle hold", {16'h0, crc_rem}, 32'h1021);
        check("R4 idle no done", {31'h0, crc_done}, 32'h0);
    endtask

    task automatic t_all_ones();
        start_block();
        for (int i = 0; i < 512; i++) send_byte(8'hFF);
        check("R3 512xFF", {16'h0, crc_rem}, 32'h7FA1);
        check("R3 model ones", {16'h0, crc_rem}, {16'h0, model});
    endtask

    task automatic t_pattern();
        logic [7:0] lf;
        lf = 8'h5A;
        start_block();
        for (int i = 0; i < 64; i++) begin
            send_byte(lf);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (i % 7 == 3) cyc(1'b0, 1'b0, 1'b1);
        end
        check("R3 pattern", {16'h0, crc_rem}, {16'h0, model});
    endtask

    task automatic t_tx();
        logic [15:0] got;
        start_block();
        send_byte(8'hC3); send_byte(8'h17);
        crc_phase = 1'b1; tx_dir = 1'b1;
        got = '0;
        for (int k = 0; k < 16; k++) begin
            cyc(1'b0, 1'b1, 1'b0);
            got = {got[14:0], tx_seen};
            if (k < 15) check("R9 no early done", {31'h0, crc_done}, 32'h0);
        end
        check("R6 tx msb first", {16'h0, got}, {16'h0, model});
        check("R6 rem frozen", {16'h0, crc_rem}, {16'h0, model});
        check("R7 tx done", {31'h0, crc_done}, 32'h1);
        check("R7 tx no fail", {31'h0, crc_fail}, 32'h0);
        cyc(1'b0, 1'b1, 1'b0);
        check("R9 done pulse", {31'h0, crc_done}, 32'h0);
        check("R8 tx bit after end", {31'h0, tx_seen}, 32'h0);
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b1, 1'b0);
            check("R8 extra strobe", {31'h0, crc_done}, 32'h0);
        end
        crc_phase = 1'b0;
    endtask

    task automatic t_rx(logic flip, int pos);
        logic [15:0] rx;
        start_block();
        send_byte(8'h3C); send_byte(8'hA5); send_byte(8'h01);
        rx = model;
        if (flip) rx[15-pos] = ~rx[15-pos];
        crc_phase = 1'b1; tx_dir = 1'b0;
        for (int k = 0; k < 16; k++) cyc(1'b0, 1'b1, rx[15-k]);
        check("R7 rx done", {31'h0, crc_done}, 32'h1);
        check("R7 rx fail", {31'h0, crc_fail}, {31'h0, flip});
        check("R6 rx rem frozen", {16'h0, crc_rem}, {16'h0, model});
        cyc(1'b0, 1'b0, 1'b0);
        check("R9 fail pulse", {31'h0, crc_fail}, 32'h0);
        check("R9 done pulse rx", {31'h0, crc_done}, 32'h0);
        crc_phase = 1'b0;
    endtask

    task automatic t_clear();
        start_block();
        send_byte(8'h9E);
        check("R3 before clear", {16'h0, crc_rem}, {16'h0, model});
        cyc(1'b1, 1'b1, 1'b1);
        check("R2 clear priority", {16'h0, crc_rem}, 32'h0);
    endtask

    task automatic t_stream();
        logic [15:0] held;
        start_block();
        send_byte(8'h42);
        held = crc_rem;
        stream_mode = 1'b1;
        send_byte(8'hFF);
        check("R5 data ignored", {16'h0, crc_rem}, {16'h0, held});
        cyc(1'b1, 1'b0, 1'b0);
        check("R5 start ignored", {16'h0, crc_rem}, {16'h0, held});
        crc_phase = 1'b1; tx_dir = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b1, 1'b1);
            if (crc_done !== 1'b0 || tx_seen !== 1'b0) begin
                check("R5 stream quiet", {30'h0, crc_done, tx_seen}, 32'h0);
            end
        end
        check("R5 stream no done", {31'h0, crc_done}, 32'h0);
        check("R5 stream rem", {16'h0, crc_rem}, {16'h0, held});
        crc_phase = 1'b0;
        stream_mode = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_single_and_idle();
        t_all_ones();
        t_pattern();
        t_tx();
        t_rx(1'b0, 0);
        t_rx(1'b1, 7);
        t_rx(1'b1, 15);
        t_clear();
        t_stream();
        finish_run();
    end
endmodule